// File: doc/BRIEF.md
# Configurable LUT Memory Cell

A sixteen-bit storage cell that one select bus reads as a 16-to-1 multiplexer. The same array serves three uses, chosen by a mode input. In fixed mode the stored pattern acts as a four-input truth table and is never altered. In RAM mode a one-hot decode of the select bus steers a single data bit into one addressed location. In shift mode the whole array moves up by one place on each enabled edge, so the select bus picks a tap and gives a delay line of programmable length.

Contents are set up through a dedicated load port that writes all sixteen bits at once and takes priority over every mode. This port plays the part of configuration. The read path has no register stage, so the output follows the select bus and the stored bits within the same cycle.

Top module: `lut_cell`

## Requirements
- R1: A synchronous active-high `rst` clears all sixteen stored bits to 0, so `dout` reads 0 for every select value.
- R2: `dout` presents stored bit `sel`: `sel` = 4'b0000 gives bit 0 and `sel` = 4'b1111 gives bit 15. The output is combinational in `sel`.
- R3: With `init_load` high, a rising edge copies `init_bits[i]` into bit i for all i. This happens whatever the values of `mode`, `we` and `din`.
- R4: In RAM mode (`mode` = 2'd1) with `we` high, a rising edge writes `din` into bit `sel` only. The other fifteen bits keep their values.
- R5: In RAM mode or shift mode with `we` low, no stored bit changes.
- R6: In shift mode (`mode` = 2'd2) with `we` high, a rising edge moves `din` into bit 0 and the old bit n-1 into bit n. The old bit 15 is lost.
- R7: In shift mode, a `din` value taken on an enabled edge appears on `dout` with `sel` = k after k+1 enabled edges.
- R8: In fixed mode (`mode` = 2'd0), and with the unused code `mode` = 2'd3, `clk` and `we` have no effect on the contents.
- R9: After a RAM write, `dout` shows the new value in the cycle that follows that edge, with the same `sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| mode | input | 2 | 0 fixed, 1 RAM, 2 shift, 3 treated as fixed |
| we | input | 1 | Write / shift enable |
| din | input | 1 | RAM write data and serial shift input |
| sel | input | 4 | Read select, RAM address, shift tap |
| init_load | input | 1 | Parallel load strobe |
| init_bits | input | 16 | Parallel load value |
| dout | output | 1 | Selected stored bit |

## Verification
The properties assume that `mode`, `we`, `din`, `sel` and `init_load` are known and steady around each rising edge. They also assume the load strobe is the only path that changes more than one bit outside shift mode. The stimulus changes every input just after a falling edge and holds it through the next rising edge. `sel` is swept between edges only to read contents; the mode during that time either cannot write or is idle until the edge. Reset is applied only at clock-aligned points, so each property's one-cycle history starts from a cleared array.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
  typedef enum logic [1:0] {
    CELL_FIXED = 2'd0,
    CELL_RAM   = 2'd1,
    CELL_SHIFT = 2'd2,
    CELL_RSVD  = 2'd3
  } cell_mode_e;
endpackage

// File: rtl/lut_cell_decode.sv
// One-hot address decode, gated by an enable.
module lut_cell_decode #(
  parameter int SEL_W = 4,
  parameter int DEPTH = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             en,
  output logic [DEPTH-1:0] hot
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_dec
    assign hot[i] = en && (sel == SEL_W'(i));
  end
endmodule

// File: rtl/lut_cell_store.sv
// Bit array: load has priority, then per-bit RAM strobe, then shift.
module lut_cell_store #(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_load,
  input  logic [DEPTH-1:0] init_bits,
  input  logic [DEPTH-1:0] ram_hot,
  input  logic             shift_en,
  input  logic             din,
  output logic [DEPTH-1:0] bits
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_bit
    logic shift_src;
    if (i == 0) begin : g_head
      assign shift_src = din;
    end else begin : g_chain
      assign shift_src = bits[i-1];
    end

    always_ff @(posedge clk) begin
      if (rst)             bits[i] <= 1'b0;
      else if (init_load)  bits[i] <= init_bits[i];
      else if (ram_hot[i]) bits[i] <= din;
      else if (shift_en)   bits[i] <= shift_src;
    end
  end
endmodule

// File: rtl/lut_cell_mux.sv
// Combinational read select.
module lut_cell_mux #(
  parameter int SEL_W = 4,
  parameter int DEPTH = 1 << SEL_W
) (
  input  logic [DEPTH-1:0] bits,
  input  logic [SEL_W-1:0] sel,
  output logic             dout
);
  assign dout = bits[sel];
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
#(
  parameter int SEL_W = 4,
  localparam int DEPTH = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             we,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  input  logic             init_load,
  input  logic [DEPTH-1:0] init_bits,
  output logic             dout
);
  cell_mode_e       mode_e;
  logic             ram_en;
  logic             shift_en;
  logic [DEPTH-1:0] ram_hot;
  logic [DEPTH-1:0] cell_bits;

  assign mode_e   = cell_mode_e'(mode);
  assign ram_en   = we && (mode_e == CELL_RAM);
  assign shift_en = we && (mode_e == CELL_SHIFT);

  lut_cell_decode #(.SEL_W(SEL_W), .DEPTH(DEPTH)) u_dec (
    .sel (sel),
    .en  (ram_en),
    .hot (ram_hot)
  );

  lut_cell_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst       (rst),
    .init_load (init_load),
    .init_bits (init_bits),
    .ram_hot   (ram_hot),
    .shift_en  (shift_en),
    .din       (din),
    .bits      (cell_bits)
  );

  lut_cell_mux #(.SEL_W(SEL_W), .DEPTH(DEPTH)) u_mux (
    .bits (cell_bits),
    .sel  (sel),
    .dout (dout)
  );
endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk #(
  parameter int SEL_W = 4,
  parameter int DEPTH = 1 << SEL_W
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic             we,
  input logic             din,
  input logic [SEL_W-1:0] sel,
  input logic             init_load,
  input logic [DEPTH-1:0] init_bits,
  input logic [DEPTH-1:0] bits,
  input logic             dout
);
  a_r1_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bits == '0));

  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    init_load |=> (bits == $past(init_bits)));

  a_r4_single_write: assert property (@(posedge clk) disable iff (rst)
    (!init_load && we && mode == 2'd1) |=>
      ((((bits ^ $past(bits)) & ~(DEPTH'(1) << $past(sel))) == '0) &&
       (bits[$past(sel)] == $past(din))));

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!init_load && !we) |=> $stable(bits));

  a_r6_shift: assert property (@(posedge clk) disable iff (rst)
    (!init_load && we && mode == 2'd2) |=>
      (bits == {$past(bits[DEPTH-2:0]), $past(din)}));

  a_r8_fixed_hold: assert property (@(posedge clk) disable iff (rst)
    (!init_load && (mode == 2'd0 || mode == 2'd3)) |=> $stable(bits));

  a_r9_read_new: assert property (@(posedge clk) disable iff (rst)
    (!init_load && we && mode == 2'd1) |=>
      ((sel != $past(sel)) || (dout == $past(din))));
endmodule

bind lut_cell lut_cell_chk #(.SEL_W(SEL_W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode      (mode),
  .we        (we),
  .din       (din),
  .sel       (sel),
  .init_load (init_load),
  .init_bits (init_bits),
  .bits      (cell_bits),
  .dout      (dout)
);

// File: tb/lut_cell_test.sv
`timescale 1ns/10ps
module lut_cell_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  mode;
  logic        we;
  logic        din;
  logic [3:0]  sel;
  logic        init_load;
  logic [15:0] init_bits;
  logic        dout;

  int applied = 0;
  int bad = 0;
  bit done = 0;

  lut_cell uut (
    .clk(clk), .rst(rst), .mode(mode), .we(we), .din(din), .sel(sel),
    .init_load(init_load), .init_bits(init_bits), .dout(dout)
  );

  always #5 clk = ~clk;

  // fields: mode[25:24] we[23] din[22] sel[21:18] load[17] init[16:1] expect[0]
  localparam int NV = 15;
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 4'd0,  1'b1, 16'hA5C3, 1'b1}, // R3 load, R2 bit0
    {2'd0, 1'b1, 1'b0, 4'd0,  1'b0, 16'h0000, 1'b1}, // R8 fixed ignores we
    {2'd0, 1'b0, 1'b0, 4'd15, 1'b0, 16'h0000, 1'b1}, // R2 bit15
    {2'd0, 1'b0, 1'b0, 4'd2,  1'b0, 16'h0000, 1'b0}, // R2 bit2
    {2'd3, 1'b1, 1'b1, 4'd2,  1'b0, 16'h0000, 1'b0}, // R8 reserved code ignored
    {2'd1, 1'b1, 1'b1, 4'd2,  1'b0, 16'h0000, 1'b1}, // R4 R9 write 1
    {2'd1, 1'b0, 1'b0, 4'd2,  1'b0, 16'h0000, 1'b1}, // R5 RAM we low
    {2'd1, 1'b1, 1'b0, 4'd15, 1'b0, 16'h0000, 1'b0}, // R4 R9 write 0
    {2'd1, 1'b0, 1'b0, 4'd1,  1'b0, 16'h0000, 1'b1}, // R4 neighbour intact
    {2'd0, 1'b0, 1'b0, 4'd14, 1'b0, 16'h0000, 1'b0}, // R4 neighbour intact
    {2'd2, 1'b1, 1'b1, 4'd0,  1'b1, 16'h0000, 1'b0}, // R3 load beats shift
    {2'd2, 1'b1, 1'b1, 4'd0,  1'b0, 16'h0000, 1'b1}, // R6 din into bit0
    {2'd2, 1'b1, 1'b0, 4'd1,  1'b0, 16'h0000, 1'b1}, // R6 move up
    {2'd2, 1'b0, 1'b1, 4'd0,  1'b0, 16'h0000, 1'b0}, // R5 shift we low
    {2'd2, 1'b1, 1'b0, 4'd2,  1'b0, 16'h0000, 1'b1}  // R7 three edges, tap 2
  };

  task automatic check(input string req, input logic got, input logic exp);
    applied++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: dout=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic w, input logic d,
                       input logic [3:0] s, input logic ld, input logic [15:0] ib);
    @(negedge clk);
    mode = m; we = w; din = d; sel = s; init_load = ld; init_bits = ib;
    @(posedge clk);
    #1;
  endtask

  // sweep all taps against an expected image (inputs idle: fixed mode)
  task automatic sweep(input string req, input logic [15:0] img);
    for (int k = 0; k < 16; k++) begin
      sel = 4'(k);
      #0.1;
      check(req, dout, img[k]);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not end, got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mode = 2'd0; we = 1'b0; din = 1'b0; sel = 4'd0;
    init_load = 1'b0; init_bits = 16'h0000;
    repeat (2) @(posedge clk);
    #1;
    sweep("R1 reset state", 16'h0000);
    @(negedge clk);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][25:24], VEC[v][23], VEC[v][22], VEC[v][21:18],
            VEC[v][17], VEC[v][16:1]);
      check($sformatf("R2-table vector %0d", v), dout, VEC[v][0]);
    end

    // R6: top bit drops out, zero enters
    drive(2'd0, 1'b0, 1'b0, 4'd0, 1'b1, 16'h8001);
    drive(2'd2, 1'b1, 1'b0, 4'd15, 1'b0, 16'h0000);
    check("R6 bit15 takes old bit14", dout, 1'b0);
    mode = 2'd0; we = 1'b0;
    sweep("R6 after shift", 16'h0002);

    // R7: single 1 walks up; tap k sees it after k+1 edges
    drive(2'd0, 1'b0, 1'b0, 4'd0, 1'b1, 16'h0000);
    drive(2'd2, 1'b1, 1'b1, 4'd0, 1'b0, 16'h0000);
    check("R7 delay 1", dout, 1'b1);
    for (int j = 2; j <= 16; j++) begin
      drive(2'd2, 1'b1, 1'b0, 4'(j - 1), 1'b0, 16'h0000);
      check($sformatf("R7 delay %0d", j), dout, 1'b1);
      mode = 2'd0; we = 1'b0;
      sel = 4'(j - 2);
      #0.1;
      check("R7 earlier tap cleared", dout, 1'b0);
    end

    // R9: overwrite and read back each address
    for (int a = 0; a < 16; a++) begin
      drive(2'd1, 1'b1, a[0], 4'(a), 1'b0, 16'h0000);
      check("R9 read after write", dout, a[0]);
    end
    mode = 2'd0; we = 1'b0;
    sweep("R4 RAM image", 16'hAAAA);

    // R1: mid-run synchronous reset
    drive(2'd0, 1'b0, 1'b0, 4'd0, 1'b1, 16'hFFFF);
    @(negedge clk);
    init_load = 1'b0; rst = 1'b1;
    @(posedge clk);
    #1;
    sweep("R1 mid-run reset", 16'h0000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule